// File: doc/BRIEF.md
# Segmented Address Translator

This block maps a 16-bit virtual address onto a physical address using a four-entry segment table held in registers. The two most significant address bits pick a table entry. The remaining fourteen bits form an offset. The offset is checked against the entry's limit and added to the entry's base. Each entry also has a present flag and a store-permission flag, so each lookup either returns a physical address or reports one of three distinct faults.

Lookups arrive on a valid/ready request channel. Each lookup carries an access kind: instruction fetch, data load or data store. Results leave one cycle later on a valid/ready response channel that holds one entry. Software rewrites table entries through a single-cycle write port. Out of reset the table holds a usable example layout: a read-only code segment, a writable data segment, a read-only shared segment and a writable stack segment.

Top module: `seg_xlate_top`

## Requirements
- R1: For a request whose entry is present, whose offset is below the limit and whose access is permitted, the response carries fault code 0 and physical address = base + offset, where segment = vaddr[15:14] and offset = vaddr[13:0].
- R2: The base-plus-offset sum wraps modulo 2^16. For example, base 0xFF00 with offset 0x0100 gives 0x0000.
- R3: An offset greater than or equal to the entry's limit gives fault code 2 (bounds). Any response with a nonzero fault code carries physical address 0x0000.
- R4: An access to an entry whose present flag is clear gives fault code 1 (invalid). This fault takes precedence over the bounds and permission faults.
- R5: Access kinds are encoded 0 = fetch, 1 = load, 2 = store, and 3 = treated as a load. A store to an entry whose store-permission flag is clear gives fault code 3 (protection), unless a bounds or invalid fault applies. Fetches and loads never give fault code 3.
- R6: After reset the table holds the following entries, all present:
  - entry 0: base 0x4000, limit 0x0800, read-only
  - entry 1: base 0x4800, limit 0x1400, writable
  - entry 2: base 0xF000, limit 0x1000, read-only
  - entry 3: base 0x0000, limit 0x3000, writable
- R7: A table write affects lookups accepted from the next cycle onward. A lookup accepted in the same cycle as the write sees the old entry.
- R8: A request accepted at a rising edge is presented on the response port at that edge, which is a one-cycle latency. While the response is valid and not taken, it holds its value and req_ready is low. Otherwise req_ready is high.
- R9: During and immediately after reset, rsp_valid is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | 2 | Entry to write |
| tbl_base | input | 16 | New base |
| tbl_limit | input | 16 | New limit (offsets at or above it fault) |
| tbl_present | input | 1 | New present flag |
| tbl_store_ok | input | 1 | New store-permission flag |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted when high |
| req_vaddr | input | 16 | Virtual address |
| req_kind | input | 2 | Access kind (0 fetch, 1 load, 2 store, 3 load) |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result taken when high |
| rsp_paddr | output | 16 | Physical address, 0 on fault |
| rsp_fault | output | 2 | 0 none, 1 invalid, 2 bounds, 3 protection |

## Verification
Every entry of the reset table is swept with offsets on a regular stride plus the points just below, at and just above its limit and the top offset, using all three access kinds. This separates correct addition from bounds misjudgement by one, and separates a protection fault from a bounds fault. The table is then rewritten to contain:
- a base near the top of the space, which exposes missing wraparound;
- an absent entry with a zero limit, which tells invalid-over-bounds priority apart;
- a read-only entry with a tiny limit, which tells bounds-over-protection priority apart.

A lookup issued in the same cycle as a table write distinguishes old from new entry contents. A stalled response with a second request waiting checks that the result holds steady and that the input stalls.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_ALT   = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_BOUNDS  = 2'd2,
    FLT_PROTECT = 2'd3
  } fault_e;

  localparam int unsigned DFLT_ENTRIES = 4;

  // Reset layout of the table: base, limit and store permission per entry.
  function automatic logic [15:0] dflt_base(input int unsigned i);
    case (i)
      0:       return 16'h4000;
      1:       return 16'h4800;
      2:       return 16'hF000;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] dflt_limit(input int unsigned i);
    case (i)
      0:       return 16'h0800;
      1:       return 16'h1400;
      2:       return 16'h1000;
      default: return 16'h3000;
    endcase
  endfunction

  function automatic logic dflt_store_ok(input int unsigned i);
    return (i == 1) || (i == 3);
  endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned SEG_BITS = 2,
  localparam int unsigned NSEG    = 1 << SEG_BITS
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [SEG_BITS-1:0]            wr_idx,
  input  logic [ADDR_W-1:0]              wr_base,
  input  logic [ADDR_W-1:0]              wr_limit,
  input  logic                           wr_present,
  input  logic                           wr_store_ok,
  output logic [NSEG-1:0][ADDR_W-1:0]    base_q,
  output logic [NSEG-1:0][ADDR_W-1:0]    limit_q,
  output logic [NSEG-1:0]                present_q,
  output logic [NSEG-1:0]                store_ok_q
);
  import seg_xlate_pkg::*;

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    logic              hit;
    logic [ADDR_W-1:0] base_d, limit_d;
    logic              present_d, store_ok_d;
    logic [ADDR_W-1:0] rst_base, rst_limit;
    logic              rst_present, rst_store_ok;

    if (g < DFLT_ENTRIES) begin : g_dflt
      assign rst_base     = ADDR_W'(dflt_base(g));
      assign rst_limit    = ADDR_W'(dflt_limit(g));
      assign rst_present  = 1'b1;
      assign rst_store_ok = dflt_store_ok(g);
    end else begin : g_empty
      assign rst_base     = '0;
      assign rst_limit    = '0;
      assign rst_present  = 1'b0;
      assign rst_store_ok = 1'b0;
    end

    assign hit = wr_en && (wr_idx == SEG_BITS'(g));

    always_comb begin
      base_d     = base_q[g];
      limit_d    = limit_q[g];
      present_d  = present_q[g];
      store_ok_d = store_ok_q[g];
      if (hit) begin
        base_d     = wr_base;
        limit_d    = wr_limit;
        present_d  = wr_present;
        store_ok_d = wr_store_ok;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g]     <= rst_base;
        limit_q[g]    <= rst_limit;
        present_q[g]  <= rst_present;
        store_ok_q[g] <= rst_store_ok;
      end else if (hit) begin
        base_q[g]     <= base_d;
        limit_q[g]    <= limit_d;
        present_q[g]  <= present_d;
        store_ok_q[g] <= store_ok_d;
      end
    end
  end

endmodule

// File: rtl/seg_lookup.sv
module seg_lookup #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned SEG_BITS = 2,
  localparam int unsigned NSEG    = 1 << SEG_BITS,
  localparam int unsigned OFF_W   = ADDR_W - SEG_BITS
) (
  input  logic [ADDR_W-1:0]              vaddr,
  input  logic [1:0]                     kind,
  input  logic [NSEG-1:0][ADDR_W-1:0]    base_q,
  input  logic [NSEG-1:0][ADDR_W-1:0]    limit_q,
  input  logic [NSEG-1:0]                present_q,
  input  logic [NSEG-1:0]                store_ok_q,
  output logic [ADDR_W-1:0]              paddr,
  output logic [1:0]                     fault
);
  import seg_xlate_pkg::*;

  logic [SEG_BITS-1:0] sel;
  logic [OFF_W-1:0]    off;
  logic [ADDR_W-1:0]   off_ext, sum;
  logic                over, deny;

  assign sel     = vaddr[ADDR_W-1 -: SEG_BITS];
  assign off     = vaddr[OFF_W-1:0];
  assign off_ext = ADDR_W'(off);
  // Width-matched add: carry out of the top bit is dropped (wraps).
  assign sum     = base_q[sel] + off_ext;
  assign over    = off_ext >= limit_q[sel];
  assign deny    = (kind == ACC_STORE) && !store_ok_q[sel];

  // Priority: absent entry, then limit, then permission.
  always_comb begin
    paddr = '0;
    fault = FLT_NONE;
    if (!present_q[sel])  fault = FLT_INVALID;
    else if (over)        fault = FLT_BOUNDS;
    else if (deny)        fault = FLT_PROTECT;
    else                  paddr = sum;
  end

endmodule

// File: rtl/seg_resp_stage.sv
module seg_resp_stage #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_paddr,
  input  logic [1:0]        in_fault,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_paddr,
  output logic [1:0]        out_fault
);
  logic              load_en;
  logic              valid_d;

  assign in_ready = !out_valid || out_ready;
  assign load_en  = in_valid && in_ready;

  always_comb begin
    valid_d = out_valid;
    if (load_en)        valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_paddr <= '0;
      out_fault <= '0;
    end else if (load_en) begin
      out_paddr <= in_paddr;
      out_fault <= in_fault;
    end
  end

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned SEG_BITS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tbl_we,
  input  logic [SEG_BITS-1:0] tbl_idx,
  input  logic [ADDR_W-1:0]   tbl_base,
  input  logic [ADDR_W-1:0]   tbl_limit,
  input  logic                tbl_present,
  input  logic                tbl_store_ok,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_vaddr,
  input  logic [1:0]          req_kind,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [ADDR_W-1:0]   rsp_paddr,
  output logic [1:0]          rsp_fault
);
  localparam int unsigned NSEG = 1 << SEG_BITS;

  logic [NSEG-1:0][ADDR_W-1:0] base_q, limit_q;
  logic [NSEG-1:0]             present_q, store_ok_q;
  logic [ADDR_W-1:0]           lk_paddr;
  logic [1:0]                  lk_fault;

  seg_table #(.ADDR_W(ADDR_W), .SEG_BITS(SEG_BITS)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (tbl_we),
    .wr_idx     (tbl_idx),
    .wr_base    (tbl_base),
    .wr_limit   (tbl_limit),
    .wr_present (tbl_present),
    .wr_store_ok(tbl_store_ok),
    .base_q     (base_q),
    .limit_q    (limit_q),
    .present_q  (present_q),
    .store_ok_q (store_ok_q)
  );

  seg_lookup #(.ADDR_W(ADDR_W), .SEG_BITS(SEG_BITS)) u_lookup (
    .vaddr     (req_vaddr),
    .kind      (req_kind),
    .base_q    (base_q),
    .limit_q   (limit_q),
    .present_q (present_q),
    .store_ok_q(store_ok_q),
    .paddr     (lk_paddr),
    .fault     (lk_fault)
  );

  seg_resp_stage #(.ADDR_W(ADDR_W)) u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (req_valid),
    .in_ready (req_ready),
    .in_paddr (lk_paddr),
    .in_fault (lk_fault),
    .out_valid(rsp_valid),
    .out_ready(rsp_ready),
    .out_paddr(rsp_paddr),
    .out_fault(rsp_fault)
  );

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_kind,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic [1:0]        rsp_fault
);

  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

  assert_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  assert_stall_in_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  assert_fault_zero_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_fault != 2'd0) |-> (rsp_paddr == '0));

  assert_no_prot_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_kind != 2'd2) |=> rsp_fault != 2'd3);

  assert_idle_after_reset_R9: assert property (@(posedge clk)
    $rose(rst_n) |-> !rsp_valid && req_ready);

endmodule

bind seg_xlate_top seg_xlate_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_kind (req_kind),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_paddr(rsp_paddr),
  .rsp_fault(rsp_fault)
);

// File: tb/seg_xlate_top_tb_top.sv
module seg_xlate_top_tb_top;

  logic        clk;
  logic        rst_n;
  logic        tbl_we;
  logic [1:0]  tbl_idx;
  logic [15:0] tbl_base, tbl_limit;
  logic        tbl_present, tbl_store_ok;
  logic        req_valid, req_ready;
  logic [15:0] req_vaddr;
  logic [1:0]  req_kind;
  logic        rsp_valid, rsp_ready;
  logic [15:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // Bench-side copy of the table, updated only from stimulus.
  logic [15:0] m_base [4];
  logic [15:0] m_lim  [4];
  logic        m_pres [4];
  logic        m_wok  [4];

  seg_xlate_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_base(tbl_base), .tbl_limit(tbl_limit),
    .tbl_present(tbl_present), .tbl_store_ok(tbl_store_ok),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] expect_of(input logic [15:0] va, input logic [1:0] k);
    logic [1:0]  s;
    logic [15:0] o;
    s = va[15:14];
    o = {2'b00, va[13:0]};
    if (!m_pres[s])                   return {2'd1, 16'h0000};
    if (o >= m_lim[s])                return {2'd2, 16'h0000};
    if (k == 2'd2 && !m_wok[s])       return {2'd3, 16'h0000};
    return {2'd0, 16'(m_base[s] + o)};
  endfunction

  function automatic string tag_of(input logic [17:0] e, input logic [15:0] va);
    if (e[17:16] == 2'd1) return "R4 invalid";
    if (e[17:16] == 2'd2) return "R3 bounds";
    if (e[17:16] == 2'd3) return "R5 protect";
    if (32'(m_base[va[15:14]]) + 32'(va[13:0]) > 32'hFFFF) return "R2 wrap";
    return "R1 translate";
  endfunction

  // One lookup: drive at negedge, accepted at next posedge, checked at following negedge.
  task automatic lookup(input logic [15:0] va, input logic [1:0] k);
    logic [17:0] e;
    string t;
    e = expect_of(va, k);
    t = tag_of(e, va);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_kind = k; rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b1, "R8 rsp_valid", 32'(rsp_valid), 1);
    check({rsp_fault, rsp_paddr} == e, t, 32'({rsp_fault, rsp_paddr}), 32'(e));
  endtask

  task automatic tbl_write(input logic [1:0] i, input logic [15:0] b, input logic [15:0] l,
                           input logic p, input logic w);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = i; tbl_base = b; tbl_limit = l; tbl_present = p; tbl_store_ok = w;
    @(negedge clk);
    tbl_we = 1'b0;
    m_base[i] = b; m_lim[i] = l; m_pres[i] = p; m_wok[i] = w;
  endtask

  task automatic sweep_all();
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 4; k++) begin
        if (k == 3 && s != 0) continue;
        for (int o = 0; o < 16384; o += 256)
          lookup({2'(s), 14'(o)}, 2'(k));
        lookup({2'(s), 14'(m_lim[s] - 16'd1)}, 2'(k));
        lookup({2'(s), 14'(m_lim[s])}, 2'(k));
        lookup({2'(s), 14'(m_lim[s] + 16'd1)}, 2'(k));
        lookup({2'(s), 14'h3FFF}, 2'(k));
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_pres[i] = 1'b1;
      m_wok[i]  = (i == 1) || (i == 3);
    end
    m_base[0] = 16'h4000; m_lim[0] = 16'h0800;
    m_base[1] = 16'h4800; m_lim[1] = 16'h1400;
    m_base[2] = 16'hF000; m_lim[2] = 16'h1000;
    m_base[3] = 16'h0000; m_lim[3] = 16'h3000;

    rst_n = 1'b0; tbl_we = 1'b0; tbl_idx = '0; tbl_base = '0; tbl_limit = '0;
    tbl_present = 1'b0; tbl_store_ok = 1'b0;
    req_valid = 1'b0; req_vaddr = '0; req_kind = '0; rsp_ready = 1'b0;
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R9 rsp_valid in reset", 32'(rsp_valid), 0);
    check(req_ready == 1'b1, "R9 req_ready in reset", 32'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R9 rsp_valid after reset", 32'(rsp_valid), 0);

    // R6: fixed points of the reset table.
    lookup(16'h0240, 2'd0);
    check(rsp_paddr == 16'h4240, "R6 code example", 32'(rsp_paddr), 32'h4240);
    lookup(16'h4050, 2'd1);
    check(rsp_paddr == 16'h4850, "R6 data example", 32'(rsp_paddr), 32'h4850);
    lookup(16'h0010, 2'd2);
    check(rsp_fault == 2'd3, "R6 code read-only", 32'(rsp_fault), 3);
    sweep_all();

    // R7: write and lookup in the same cycle; lookup must see the old entry.
    begin
      logic [17:0] e_old;
      e_old = expect_of(16'h4100, 2'd1);
      @(negedge clk);
      tbl_we = 1'b1; tbl_idx = 2'd1; tbl_base = 16'h1000; tbl_limit = 16'h0200;
      tbl_present = 1'b1; tbl_store_ok = 1'b1;
      req_valid = 1'b1; req_vaddr = 16'h4100; req_kind = 2'd1; rsp_ready = 1'b1;
      @(negedge clk);
      tbl_we = 1'b0; req_valid = 1'b0;
      m_base[1] = 16'h1000; m_lim[1] = 16'h0200; m_pres[1] = 1'b1; m_wok[1] = 1'b1;
      check({rsp_fault, rsp_paddr} == e_old, "R7 old entry same cycle",
            32'({rsp_fault, rsp_paddr}), 32'(e_old));
      lookup(16'h4100, 2'd1);
      check(rsp_paddr == 16'h1100, "R7 new entry next cycle", 32'(rsp_paddr), 32'h1100);
    end

    // Rewritten layout: wrap, absent, tight read-only.
    tbl_write(2'd0, 16'hFF00, 16'h0400, 1'b1, 1'b1);
    tbl_write(2'd2, 16'h2000, 16'h0000, 1'b0, 1'b1);
    tbl_write(2'd3, 16'h8000, 16'h0010, 1'b1, 1'b0);
    lookup(16'h0100, 2'd2);
    check(rsp_paddr == 16'h0000 && rsp_fault == 2'd0, "R2 wrap to zero", 32'(rsp_paddr), 0);
    lookup(16'h8005, 2'd2);
    check(rsp_fault == 2'd1, "R4 invalid over bounds", 32'(rsp_fault), 1);
    lookup(16'hC020, 2'd2);
    check(rsp_fault == 2'd2, "R3 bounds over protect", 32'(rsp_fault), 2);
    lookup(16'hC005, 2'd3);
    check(rsp_fault == 2'd0 && rsp_paddr == 16'h8005, "R5 kind 3 reads", 32'(rsp_paddr), 32'h8005);
    sweep_all();

    // R8: stalled response holds and blocks the input.
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 16'hC003; req_kind = 2'd0; rsp_ready = 1'b0;
    @(negedge clk);
    req_vaddr = 16'hC00F; req_kind = 2'd1;
    check(rsp_valid && rsp_paddr == 16'h8003, "R8 first result", 32'(rsp_paddr), 32'h8003);
    check(req_ready == 1'b0, "R8 stall input", 32'(req_ready), 0);
    @(negedge clk);
    check(rsp_valid && rsp_paddr == 16'h8003, "R8 result held", 32'(rsp_paddr), 32'h8003);
    check(req_ready == 1'b0, "R8 still stalled", 32'(req_ready), 0);
    rsp_ready = 1'b1;
    #1;
    check(req_ready == 1'b1, "R8 ready when taken", 32'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && rsp_paddr == 16'h800F, "R8 second result", 32'(rsp_paddr), 32'h800F);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R8 drained", 32'(rsp_valid), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R8 watchdog act=%h exp=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule